// File: doc/BRIEF.md
# DRAM Bank Access Sequencer

This block turns single read and write requests into the command stream for one DRAM bank. A request arrives as a flat address. The upper bits select a row and the lower bits select a column group. The sequencer remembers which row, if any, is latched in the bank's sense amplifiers.

- A request to that open row goes straight to the column command.
- A request to another row first closes the bank with a precharge, then activates the new row, then issues the column command.
- A request to a closed bank activates the row and then issues the column command.

Row and column numbers share one multiplexed address bus and go out in separate command cycles. Three configuration inputs set the minimum cycle distances:

- activate to column command;
- column read to data return;
- precharge to the next activate.

A single down-counter enforces whichever of these distances is pending. The requester sees a valid/ready handshake that holds at most one request in flight. Read data comes back with a one-cycle valid pulse. The width of a column group is a parameter.

Top module: `bank_seq`

## Requirements
- R1: After reset, no row is open, `req_ready` is 1, `cmd_code` is NOP and `rsp_valid` is 0.
- R2: A request whose row equals the open row issues its column command in the cycle after acceptance, with no precharge and no activate.
- R3: A request to a row other than the open row issues a precharge in the cycle after acceptance. The activate follows max(`cfg_trp`,1) cycles after the precharge. An activate never reaches an open bank, and a precharge never reaches a closed one.
- R4: A request to a closed bank issues an activate in the cycle after acceptance, with no precharge.
- R5: A column command follows its activate by exactly max(`cfg_trcd`,1) cycles, and only while a row is open.
- R6: For a read, `dram_rdata` is sampled max(`cfg_tcl`,1) cycles after the read command. `rsp_valid` is then high for exactly one cycle, the next one, with that value on `rsp_rdata`.
- R7: A write issues a WR command carrying `req_wdata` on `cmd_wdata` and produces no `rsp_valid`. A later read of the same address returns the written value.
- R8: Only one request is outstanding. `req_ready` is 0 from the cycle after acceptance until the access completes. A request presented while `req_ready` is 0 is ignored and produces no command.
- R9: The row is the upper ROW_W bits of `req_addr` and the column is the lower COL_W bits. Each is sent zero-extended on `cmd_addr`: the row in the activate cycle and the column in the column-command cycle.
- R10: `cmd_code` encodes NOP=0, ACT=1, RD=2, WR=3, PRE=4. No other value appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_trcd | input | TW | Activate-to-column delay in cycles (0 acts as 1) |
| cfg_tcl | input | TW | Read-to-data delay in cycles (0 acts as 1) |
| cfg_trp | input | TW | Precharge-to-activate delay in cycles (0 acts as 1) |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address {row, column} |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | DATA_W | Read data |
| cmd_code | output | 3 | Bank command (see R10) |
| cmd_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| cmd_wdata | output | DATA_W | Data carried with WR |
| dram_rdata | input | DATA_W | Data returned by the bank |

## Verification
All timings below count from the acceptance cycle `a`, which is the cycle where `req_valid` and `req_ready` are both high.

| Access kind | Column command issues in cycle |
|---|---|
| Row hit | a+1 |
| Closed bank | a+1+max(trcd,1) |
| Row miss | a+1+max(trp,1)+max(trcd,1) |

For a read, `rsp_valid` is due exactly max(tcl,1)+1 cycles after the read command.

The bench derives each of these cycle numbers from the configuration and from its own record of the open row. It compares them against the cycles in which a bank model observed each command, sampling mid-cycle. The bank model drives `dram_rdata` only in the one cycle where read data is due and drives a poison value in every other cycle. A capture in the wrong cycle therefore shows up as a wrong value, not only as a wrong time.

// File: rtl/bank_seq_pkg.sv
// Shared types of the bank sequencer.
// Command codes are visible on the cmd_code port; their values are fixed.
package bank_seq_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PRE    = 3'd1,
        ST_ACT    = 3'd2,
        ST_COL    = 3'd3,
        ST_RDWAIT = 3'd4
    } state_e;

endpackage

// File: rtl/bank_seq_timer.sv
// Spacing counter shared by all bank timing rules.
// A load of delay N makes 'zero' true again N cycles later; N=0 behaves as 1.
// Assumes: load is only asserted while the counter is already zero.
module bank_seq_timer #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] delay,
    output logic          zero
);

    logic [TW-1:0] cnt_q;

    // Count down to zero, reloading on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= (delay == '0) ? '0 : (delay - 1'b1);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

    assert_load_when_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> zero);

endmodule

// File: rtl/bank_seq_rowtrack.sv
// Open-row register of the bank.
// It records which row is latched and compares it with an incoming row.
// Assumes: open and close are never requested in the same cycle.
module bank_seq_rowtrack #(
    parameter int ROW_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             open_en,
    input  logic             close_en,
    input  logic [ROW_W-1:0] open_row,
    input  logic [ROW_W-1:0] probe_row,
    output logic             row_valid,
    output logic             probe_hit
);

    logic [ROW_W-1:0] row_q;
    logic             valid_q;

    // Track the open/closed state and the latched row number.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            row_q   <= '0;
        end else if (open_en) begin
            valid_q <= 1'b1;
            row_q   <= open_row;
        end else if (close_en) begin
            valid_q <= 1'b0;
        end
    end

    assign row_valid = valid_q;
    assign probe_hit = valid_q && (row_q == probe_row);

    assert_open_records_R9: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |=> (row_valid && (row_q == $past(open_row))));

    assert_act_needs_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        open_en |-> !row_valid);

    assert_pre_needs_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |-> row_valid);

    assert_close_takes_R3: assert property (@(posedge clk) disable iff (!rst_n)
        close_en |=> !row_valid);

endmodule

// File: rtl/bank_seq_ctrl.sv
// Command sequencer for one bank.
// It latches a request and walks PRE -> ACT -> column as the open row demands.
// It waits on the spacing timer before each timed step and captures read data.
// Assumes: the row tracker's hit/valid reflect the bank before this cycle's command.
module bank_seq_ctrl
    import bank_seq_pkg::*;
#(
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int TW     = 4,
    parameter int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [TW-1:0]     cfg_tcl,
    input  logic [TW-1:0]     cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              row_valid,
    input  logic              row_hit,
    input  logic              tmr_zero,
    output logic              tmr_load,
    output logic [TW-1:0]     tmr_delay,
    output logic              open_en,
    output logic              close_en,
    output logic [ROW_W-1:0]  open_row,
    output cmd_e              cmd,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] dram_rdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata
);

    state_e            state_q, state_d;
    logic              pend_wr_q;
    logic [ROW_W-1:0]  pend_row_q;
    logic [COL_W-1:0]  pend_col_q;
    logic [DATA_W-1:0] pend_wdata_q;
    logic              accept;
    logic              capture;
    logic              rsp_valid_q;
    logic [DATA_W-1:0] rsp_rdata_q;

    assign req_ready = (state_q == ST_IDLE) && tmr_zero;
    assign accept    = req_valid && req_ready;
    assign open_row  = pend_row_q;

    // Next state, command outputs and timer loads for the current step.
    always_comb begin
        state_d   = state_q;
        cmd       = CMD_NOP;
        cmd_addr  = '0;
        cmd_wdata = '0;
        tmr_load  = 1'b0;
        tmr_delay = '0;
        open_en   = 1'b0;
        close_en  = 1'b0;
        capture   = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    if (row_hit) begin
                        state_d = ST_COL;
                    end else if (row_valid) begin
                        state_d = ST_PRE;
                    end else begin
                        state_d = ST_ACT;
                    end
                end
            end
            ST_PRE: begin
                cmd       = CMD_PRE;
                close_en  = 1'b1;
                tmr_load  = 1'b1;
                tmr_delay = cfg_trp;
                state_d   = ST_ACT;
            end
            ST_ACT: begin
                if (tmr_zero) begin
                    cmd                  = CMD_ACT;
                    cmd_addr[ROW_W-1:0]  = pend_row_q;
                    open_en              = 1'b1;
                    tmr_load             = 1'b1;
                    tmr_delay            = cfg_trcd;
                    state_d              = ST_COL;
                end
            end
            ST_COL: begin
                if (tmr_zero) begin
                    cmd_addr[COL_W-1:0] = pend_col_q;
                    if (pend_wr_q) begin
                        cmd       = CMD_WR;
                        cmd_wdata = pend_wdata_q;
                        state_d   = ST_IDLE;
                    end else begin
                        cmd       = CMD_RD;
                        tmr_load  = 1'b1;
                        tmr_delay = cfg_tcl;
                        state_d   = ST_RDWAIT;
                    end
                end
            end
            ST_RDWAIT: begin
                if (tmr_zero) begin
                    capture = 1'b1;
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Hold the accepted request for the whole access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_wr_q    <= 1'b0;
            pend_row_q   <= '0;
            pend_col_q   <= '0;
            pend_wdata_q <= '0;
        end else if (accept) begin
            pend_wr_q    <= req_write;
            pend_row_q   <= req_row;
            pend_col_q   <= req_col;
            pend_wdata_q <= req_wdata;
        end
    end

    // Capture read data and raise the one-cycle response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= capture;
            if (capture) begin
                rsp_rdata_q <= dram_rdata;
            end
        end
    end

    assign rsp_valid = rsp_valid_q;
    assign rsp_rdata = rsp_rdata_q;

    assert_one_outstanding_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_rsp_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_col_needs_row_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == CMD_RD) || (cmd == CMD_WR)) |-> row_valid);

    assert_write_no_rsp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_WR) |=> !rsp_valid);

endmodule

// File: rtl/bank_seq.sv
// Top of the one-bank DRAM access sequencer.
// Splits the flat request address into row and column and ties together
// the sequencer, the open-row register and the spacing timer.
// Assumes: timing configuration is changed only while the block is idle.
module bank_seq #(
    parameter int ROW_W  = 14,
    parameter int COL_W  = 10,
    parameter int DATA_W = 16,
    parameter int TW     = 4,
    localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
    localparam int REQ_W  = ROW_W + COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TW-1:0]     cfg_trcd,
    input  logic [TW-1:0]     cfg_tcl,
    input  logic [TW-1:0]     cfg_trp,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [REQ_W-1:0]  req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [2:0]        cmd_code,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_wdata,
    input  logic [DATA_W-1:0] dram_rdata
);

    import bank_seq_pkg::*;

    logic [ROW_W-1:0] req_row;
    logic [COL_W-1:0] req_col;
    logic             row_valid, row_hit;
    logic             tmr_zero, tmr_load;
    logic [TW-1:0]    tmr_delay;
    logic             open_en, close_en;
    logic [ROW_W-1:0] open_row;
    cmd_e             cmd;

    assign req_row  = req_addr[REQ_W-1:COL_W];
    assign req_col  = req_addr[COL_W-1:0];
    assign cmd_code = cmd;

    bank_seq_ctrl #(
        .ROW_W (ROW_W),
        .COL_W (COL_W),
        .DATA_W(DATA_W),
        .TW    (TW),
        .ADDR_W(ADDR_W)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_trcd  (cfg_trcd),
        .cfg_tcl   (cfg_tcl),
        .cfg_trp   (cfg_trp),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_row   (req_row),
        .req_col   (req_col),
        .req_wdata (req_wdata),
        .row_valid (row_valid),
        .row_hit   (row_hit),
        .tmr_zero  (tmr_zero),
        .tmr_load  (tmr_load),
        .tmr_delay (tmr_delay),
        .open_en   (open_en),
        .close_en  (close_en),
        .open_row  (open_row),
        .cmd       (cmd),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .dram_rdata(dram_rdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata)
    );

    bank_seq_rowtrack #(
        .ROW_W(ROW_W)
    ) u_rows (
        .clk      (clk),
        .rst_n    (rst_n),
        .open_en  (open_en),
        .close_en (close_en),
        .open_row (open_row),
        .probe_row(req_row),
        .row_valid(row_valid),
        .probe_hit(row_hit)
    );

    bank_seq_timer #(
        .TW(TW)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (tmr_load),
        .delay(tmr_delay),
        .zero (tmr_zero)
    );

    assert_cmd_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code <= 3'd4);

endmodule

// File: tb/tb_bank_seq.sv
// Sweeps every delay setting 0..3 of a small bank sequencer.
// A behavioural bank model checks command spacing and provides read data.
module tb_bank_seq;

    localparam int ROW_W  = 3;
    localparam int COL_W  = 2;
    localparam int DATA_W = 8;
    localparam int TW     = 3;
    localparam int ADDR_W = 3;
    localparam int REQ_W  = 5;
    localparam int NLOC   = 32;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst_n = 1'b0;
    logic [TW-1:0]     cfg_trcd = '0, cfg_tcl = '0, cfg_trp = '0;
    logic              req_valid = 1'b0, req_write = 1'b0;
    logic              req_ready;
    logic [REQ_W-1:0]  req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              rsp_valid;
    logic [DATA_W-1:0] rsp_rdata;
    logic [2:0]        cmd_code;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_wdata;
    logic [DATA_W-1:0] dram_rdata = 8'hEE;

    bank_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .TW(TW)) dut (
        .clk(clk), .rst_n(rst_n), .cfg_trcd(cfg_trcd), .cfg_tcl(cfg_tcl), .cfg_trp(cfg_trp),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .cmd_code(cmd_code), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .dram_rdata(dram_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clamp1(input int v);
        return (v < 1) ? 1 : v;
    endfunction

    // Bank model state.
    logic [DATA_W-1:0] dmem [NLOC];
    bit  m_open = 0, m_pre_seen = 0, m_last_col_wr = 0;
    int  m_row = 0, m_act_cyc = 0, m_pre_cyc = 0, m_rd_due = -1;
    int  m_act_cnt = 0, m_pre_cnt = 0, m_col_cnt = 0;
    int  m_last_col_cyc = 0, m_last_col_addr = 0, m_last_act_row = 0;
    logic [DATA_W-1:0] m_rd_val = '0;

    // Bank model: observes each command mid-cycle and drives read data when due.
    always @(negedge clk) begin
        if (!rst_n) begin
            m_open = 0; m_pre_seen = 0; m_rd_due = -1; dram_rdata = 8'hEE;
        end else begin
            case (cmd_code)
                3'd0: ;
                3'd1: begin
                    checks++;
                    if (m_open || (m_pre_seen && (cyc - m_pre_cyc < clamp1(int'(cfg_trp))))) begin
                        errors++;
                        $display("FAIL R3 activate spacing/open actual open=%0d gap=%0d expected closed gap>=%0d",
                                 m_open, cyc - m_pre_cyc, clamp1(int'(cfg_trp)));
                    end
                    m_open = 1; m_row = int'(cmd_addr); m_act_cyc = cyc;
                    m_act_cnt++; m_last_act_row = int'(cmd_addr);
                end
                3'd2, 3'd3: begin
                    int idx;
                    checks++;
                    if (!m_open || (cyc - m_act_cyc < clamp1(int'(cfg_trcd)))) begin
                        errors++;
                        $display("FAIL R5 column spacing actual open=%0d gap=%0d expected open gap>=%0d",
                                 m_open, cyc - m_act_cyc, clamp1(int'(cfg_trcd)));
                    end
                    m_col_cnt++; m_last_col_cyc = cyc; m_last_col_addr = int'(cmd_addr);
                    m_last_col_wr = (cmd_code == 3'd3);
                    idx = m_row * 4 + int'(cmd_addr[COL_W-1:0]);
                    if (cmd_code == 3'd3) begin
                        dmem[idx] = cmd_wdata;
                    end else begin
                        m_rd_due = cyc + clamp1(int'(cfg_tcl));
                        m_rd_val = dmem[idx];
                    end
                end
                3'd4: begin
                    checks++;
                    if (!m_open) begin
                        errors++;
                        $display("FAIL R3 precharge of closed bank actual closed expected open");
                    end
                    m_open = 0; m_pre_seen = 1; m_pre_cyc = cyc; m_pre_cnt++;
                end
                default: begin
                    checks++; errors++;
                    $display("FAIL R10 illegal command actual %0d expected 0..4", cmd_code);
                end
            endcase
            dram_rdata = (cyc == m_rd_due) ? m_rd_val : 8'hEE;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    logic [DATA_W-1:0] exp_mem [NLOC];
    bit exp_open = 0;
    int exp_row = 0;

    // One request; expected command cycles derived from the delays and the open row.
    task automatic do_req(input bit w, input int row, input int col, input int wd);
        int a, pre0, act0, col0, rsp_c, rsp_n, col_exp;
        bit pre_e, act_e;
        string t;
        int addr;
        logic [DATA_W-1:0] got;
        addr  = row * 4 + col;
        pre_e = exp_open && (exp_row != row);
        act_e = !exp_open || (exp_row != row);
        t     = pre_e ? "R3" : (act_e ? "R4" : "R2");
        pre0 = m_pre_cnt; act0 = m_act_cnt; col0 = m_col_cnt;
        req_valid = 1'b1; req_write = w; req_addr = addr[REQ_W-1:0]; req_wdata = wd[DATA_W-1:0];
        while (!req_ready) begin @(posedge clk); #2; end
        a = cyc;
        @(posedge clk); #2;
        chk("R8 ready low after accept", int'(req_ready), 0);
        // Request presented while busy must be ignored.
        req_write = 1'b1; req_addr = '0; req_wdata = 8'hFF;
        @(posedge clk); #2;
        req_valid = 1'b0;
        rsp_c = -1; rsp_n = 0; got = '0;
        forever begin
            if (rsp_valid) begin
                rsp_n++;
                if (rsp_c < 0) begin rsp_c = cyc; got = rsp_rdata; end
            end
            if (w ? (req_ready == 1'b1) : (rsp_c >= 0)) break;
            @(posedge clk); #2;
        end
        col_exp = a + 1 + (pre_e ? clamp1(int'(cfg_trp)) : 0) + (act_e ? clamp1(int'(cfg_trcd)) : 0);
        chk({t, " precharge count"}, m_pre_cnt - pre0, pre_e ? 1 : 0);
        chk({t, " activate count"}, m_act_cnt - act0, act_e ? 1 : 0);
        chk("R8 one column command per request", m_col_cnt - col0, 1);
        chk({t, " R5 column command cycle"}, m_last_col_cyc - a, col_exp - a);
        chk("R9 column address", m_last_col_addr, col);
        chk("R10 column command kind", int'(m_last_col_wr), int'(w));
        if (act_e) chk("R9 activate row address", m_last_act_row, row);
        if (w) begin
            chk("R7 write gives no response", rsp_n, 0);
            exp_mem[addr] = wd[DATA_W-1:0];
        end else begin
            chk("R6 response cycle", rsp_c - col_exp, clamp1(int'(cfg_tcl)) + 1);
            chk("R6 R7 read data", int'(got), int'(exp_mem[addr]));
            @(posedge clk); #2;
            chk("R6 response is one pulse", int'(rsp_valid), 0);
        end
        exp_open = 1; exp_row = row;
    endtask

    initial begin
        for (int i = 0; i < NLOC; i++) begin
            dmem[i]    = DATA_W'(i * 7 + 3);
            exp_mem[i] = DATA_W'(i * 7 + 3);
        end
        repeat (3) @(posedge clk);
        for (int k = 0; k < 64; k++) begin
            cfg_trp  = TW'(k % 4);
            cfg_trcd = TW'((k / 4) % 4);
            cfg_tcl  = TW'(k / 16);
            #2; rst_n = 1'b0;
            repeat (2) @(posedge clk);
            #2; rst_n = 1'b1;
            exp_open = 0;
            chk("R1 ready after reset", int'(req_ready), 1);
            chk("R1 NOP after reset", int'(cmd_code), 0);
            chk("R1 no response after reset", int'(rsp_valid), 0);
            do_req(1'b0, 2, 1, 0);        // closed bank
            do_req(1'b1, 2, 1, 8'h30 + k); // hit write
            do_req(1'b0, 2, 1, 0);        // hit read of written value
            do_req(1'b0, 2, 3, 0);        // hit, other column
            do_req(1'b1, 5, 0, 8'h31 + k); // miss write
            do_req(1'b0, 5, 0, 0);        // hit read
            do_req(1'b0, 2, 1, 0);        // miss read
            do_req(1'b0, 0, 0, 0);        // ignored busy writes never landed
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual hung expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule